// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources and drives a single combined interrupt line toward a host processor. Software programs it through four word-wide registers on a simple register bus: a configuration word, a per-source enable mask, an in-service set, and a vector register. Each source owns the bit whose position equals its source number in both the mask and the in-service set.

The host takes an interrupt in two steps. It writes a 1 into bit 0 of the vector register to arm the acknowledge. It then reads the same register, and bits [15:11] of the returned word hold the number of the winning source. That read marks the winner as in service, and the mark stays until software writes a one to the winner's bit in the in-service register. Priority is fixed, with a higher source number ranking above a lower one. Four serial-channel sources can be shuffled among their four priority slots, and one programmable source can be lifted above every other source. When nothing qualifies at acknowledge time, for example because a request was masked after the line rose, the read returns the error vector. Software only has to acknowledge that vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the configuration, mask and in-service registers read as zero, `irq_o` is low, and a vector read with no prior arm returns zero.
- R2: A pending source can raise `irq_o` only while its mask bit is 1. The mask register is at address 1, and bit n of the mask belongs to source n.
- R3: `irq_o` stays low while configuration bit 16 (global enable) is 0, even when an unmasked source is pending.
- R4: Among ordinary sources, the pending unmasked source with the highest number wins the acknowledge.
- R5: Serial channel j is source 24+j. Configuration bits [2j+1:2j] give that channel's slot s, and the channel then ranks as source 24+s. When two sources have equal rank, the one with the higher source number wins.
- R6: The source named in configuration bits [12:8] ranks above every other source.
- R7: Writing 1 to bit 0 of the vector register (address 3) arms the acknowledge. The next read of address 3 returns the winner's number in bits [15:11] with bits [10:0] zero, and sets that source's in-service bit. A vector read that is not armed returns the last vector word and changes nothing.
- R8: While any source is in service, only pending sources of strictly higher rank can raise `irq_o` or win an acknowledge.
- R9: Writing a word to the in-service register (address 2) clears every in-service bit that is 1 in the word.
- R10: An armed vector read with no qualifying source returns vector 0, the error vector, and marks nothing in service. The request line of source 0 never raises an interrupt.
- R11: Requests are level-sensitive: a request that drops before it is acknowledged no longer holds `irq_o`. Configuration bits [15:13] appear on `irq_level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the following cycle |
| bus_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_i | input | 32 | Level-sensitive source requests |
| irq_o | output | 1 | Combined interrupt to the host |
| irq_level_o | output | 3 | Programmed request level toward the host |

## Verification
The assertions assume that the requests are synchronous to `clk` and that a read and a write never arrive in the same cycle. They also assume software only arms the acknowledge before it reads the vector register, as the two-step protocol requires. The bench drives every bus strobe as a single-cycle pulse that is launched at the falling edge. It changes requests only between bus operations, so no request moves during an acknowledge read. Under these conditions each acknowledge sees stable candidates, and every vector and in-service value has one expected value that the requirements fix.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [1:0] {
      REG_CFG   = 2'd0,
      REG_MASK  = 2'd1,
      REG_INSVC = 2'd2,
      REG_VEC   = 2'd3
   } vic_reg_e;

   localparam int CFG_W        = 17;
   localparam int CFG_SLOT_LSB = 0;
   localparam int CFG_TOP_LSB  = 8;
   localparam int CFG_TOP_W    = 5;
   localparam int CFG_LVL_LSB  = 13;
   localparam int CFG_LVL_W    = 3;
   localparam int CFG_EN_BIT   = 16;
   localparam int VEC_WORD_W   = 16;
   localparam int VEC_NUM_LSB  = 11;
endpackage

// File: rtl/vic_rank.sv
module vic_rank #(
   parameter int N_SRC   = 32,
   parameter int CH_BASE = 24,
   parameter int N_CH    = 4,
   parameter int SLOT_W  = 2,
   parameter int TOP_W   = 5,
   localparam int RANK_W = $clog2(N_SRC) + 1
) (
   input  logic [N_CH*SLOT_W-1:0]        slots_i,
   input  logic [TOP_W-1:0]              top_src_i,
   output logic [N_SRC-1:0][RANK_W-1:0]  rank_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [RANK_W-1:0] base_rank;
      if (i >= CH_BASE && i < CH_BASE + N_CH) begin : g_chan
         assign base_rank = RANK_W'(CH_BASE)
                          + RANK_W'(slots_i[(i-CH_BASE)*SLOT_W +: SLOT_W]);
      end else begin : g_plain
         assign base_rank = RANK_W'(i);
      end
      assign rank_o[i] = (top_src_i == TOP_W'(i)) ? RANK_W'(N_SRC) : base_rank;
   end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int N_SRC   = 32,
   localparam int SRC_W  = $clog2(N_SRC),
   localparam int RANK_W = SRC_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SRC-1:0]              cand_i,
   input  logic [N_SRC-1:0]              insvc_i,
   input  logic [N_SRC-1:0][RANK_W-1:0]  rank_i,
   output logic                          any_o,
   output logic [SRC_W-1:0]              win_o
);
   logic [RANK_W-1:0] ceil_rank;
   logic              ceil_v;
   logic [N_SRC-1:0]  elig;
   logic [RANK_W-1:0] best;

   // highest rank currently in service
   always_comb begin
      ceil_v    = 1'b0;
      ceil_rank = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (insvc_i[i] && (!ceil_v || rank_i[i] > ceil_rank)) begin
            ceil_v    = 1'b1;
            ceil_rank = rank_i[i];
         end
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = cand_i[i] && (!ceil_v || rank_i[i] > ceil_rank);
   end

   // highest rank wins, later index wins ties
   always_comb begin
      any_o = 1'b0;
      win_o = '0;
      best  = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!any_o || rank_i[i] >= best)) begin
            any_o = 1'b1;
            best  = rank_i[i];
            win_o = SRC_W'(i);
         end
      end
   end

   // R8
   win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (cand_i[win_o] && (!ceil_v || rank_i[win_o] > ceil_rank)));
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
   import vic_pkg::*;
#(
   parameter int N_SRC   = 32,
   parameter int ERR_VEC = 0,
   localparam int SRC_W  = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              any_i,
   input  logic [SRC_W-1:0]  win_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic [N_SRC-1:0]  mask_o,
   output logic [N_SRC-1:0]  insvc_o
);
   vic_reg_e                reg_sel;
   logic [CFG_W-1:0]        cfg_q;
   logic [N_SRC-1:0]        mask_q;
   logic [N_SRC-1:0]        insvc_q;
   logic [N_SRC-1:0]        insvc_nxt;
   logic [N_SRC-1:0]        clr_bits;
   logic [N_SRC-1:0]        set_bits;
   logic [VEC_WORD_W-1:0]   vec_q;
   logic [VEC_WORD_W-1:0]   vec_new;
   logic                    armed_q;
   logic                    ack_take;

   assign reg_sel  = vic_reg_e'(bus_addr);
   assign ack_take = bus_rd && (reg_sel == REG_VEC) && armed_q;
   assign vec_new  = any_i ? (VEC_WORD_W'(win_i) << VEC_NUM_LSB)
                           : (VEC_WORD_W'(ERR_VEC) << VEC_NUM_LSB);

   always_comb begin
      clr_bits = '0;
      set_bits = '0;
      if (bus_wr && reg_sel == REG_INSVC) clr_bits = bus_wdata[N_SRC-1:0];
      if (ack_take && any_i)              set_bits[win_i] = 1'b1;
      insvc_nxt = (insvc_q & ~clr_bits) | set_bits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         mask_q    <= '0;
         insvc_q   <= '0;
         vec_q     <= '0;
         armed_q   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         insvc_q <= insvc_nxt;
         if (bus_wr) begin
            case (reg_sel)
               REG_CFG:  cfg_q  <= bus_wdata[CFG_W-1:0];
               REG_MASK: mask_q <= bus_wdata[N_SRC-1:0];
               REG_VEC:  if (bus_wdata[0]) armed_q <= 1'b1;
               default:  ;
            endcase
         end
         if (bus_rd) begin
            case (reg_sel)
               REG_CFG:   bus_rdata <= 32'(cfg_q);
               REG_MASK:  bus_rdata <= 32'(mask_q);
               REG_INSVC: bus_rdata <= 32'(insvc_q);
               default: begin
                  if (armed_q) begin
                     armed_q   <= 1'b0;
                     vec_q     <= vec_new;
                     bus_rdata <= 32'(vec_new);
                  end else begin
                     bus_rdata <= 32'(vec_q);
                  end
               end
            endcase
         end
      end
   end

   assign cfg_o   = cfg_q;
   assign mask_o  = mask_q;
   assign insvc_o = insvc_q;

   // R7
   ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && any_i) |=> (insvc_q[$past(win_i)] &&
                               bus_rdata[VEC_NUM_LSB-1:0] == '0));
   // R10
   err_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && !any_i) |=>
         (bus_rdata[VEC_WORD_W-1:VEC_NUM_LSB] == (VEC_WORD_W-VEC_NUM_LSB)'(ERR_VEC)));
   // R9
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && reg_sel == REG_INSVC && !ack_take) |=>
         ((insvc_q & $past(bus_wdata[N_SRC-1:0])) == '0));
   // R7
   plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && reg_sel == REG_VEC && !armed_q && !bus_wr) |=> $stable(insvc_q));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int N_SRC   = 32,
   parameter int CH_BASE = 24,
   parameter int N_CH    = 4,
   parameter int SLOT_W  = 2,
   parameter int ERR_VEC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_SRC-1:0]  req_i,
   output logic              irq_o,
   output logic [2:0]        irq_level_o
);
   localparam int SRC_W  = $clog2(N_SRC);
   localparam int RANK_W = SRC_W + 1;
   localparam logic [N_SRC-1:0] ERR_BIT = N_SRC'(1) << ERR_VEC;

   if (N_SRC > 32 || N_SRC < 2) begin : g_bad_src
      $error("N_SRC must lie in 2..32");
   end
   if (CH_BASE + N_CH > N_SRC) begin : g_bad_ch
      $error("serial channels exceed the source range");
   end
   if (N_CH != (1 << SLOT_W)) begin : g_bad_slot
      $error("slot field width must address every channel slot");
   end
   if (N_CH * SLOT_W > CFG_TOP_LSB || SRC_W > CFG_TOP_W) begin : g_bad_cfg
      $error("configuration fields overlap");
   end
   if (ERR_VEC >= N_SRC) begin : g_bad_err
      $error("error vector out of range");
   end

   logic [CFG_W-1:0]                cfg;
   logic [N_SRC-1:0]                mask;
   logic [N_SRC-1:0]                insvc;
   logic [N_SRC-1:0]                cand;
   logic [N_SRC-1:0][RANK_W-1:0]    rank;
   logic                            any;
   logic [SRC_W-1:0]                win;

   assign cand = req_i & mask & ~ERR_BIT;

   vic_regfile #(.N_SRC(N_SRC), .ERR_VEC(ERR_VEC)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .any_i(any), .win_i(win),
      .cfg_o(cfg), .mask_o(mask), .insvc_o(insvc)
   );

   vic_rank #(.N_SRC(N_SRC), .CH_BASE(CH_BASE), .N_CH(N_CH),
              .SLOT_W(SLOT_W), .TOP_W(CFG_TOP_W)) u_rank (
      .slots_i(cfg[CFG_SLOT_LSB +: N_CH*SLOT_W]),
      .top_src_i(cfg[CFG_TOP_LSB +: CFG_TOP_W]),
      .rank_o(rank)
   );

   vic_arbiter #(.N_SRC(N_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .cand_i(cand), .insvc_i(insvc), .rank_i(rank),
      .any_o(any), .win_o(win)
   );

   assign irq_o       = cfg[CFG_EN_BIT] & any;
   assign irq_level_o = cfg[CFG_LVL_LSB +: CFG_LVL_W];

   // R2
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((req_i & mask) != '0));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [31:0] req;
   logic        irq;
   logic [2:0]  lvl;
   int          checks = 0;
   int          errors = 0;

   localparam logic [31:0] EN = 32'h1_0000;

   always #4 clk = ~clk;

   vec_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req_i(req), .irq_o(irq), .irq_level_o(lvl)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic ack(output logic [31:0] d);
      wr(2'd3, 32'h1);
      rd(2'd3, d);
   endtask

   task automatic set_req(input logic [31:0] r);
      @(negedge clk);
      req = r;
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq", 32'(irq), 0);
      rd(2'd0, d); check("R1 cfg", d, 0);
      rd(2'd1, d); check("R1 mask", d, 0);
      rd(2'd2, d); check("R1 insvc", d, 0);
      rd(2'd3, d); check("R1 vec", d, 0);
   endtask

   task automatic t_mask_enable();
      wr(2'd0, EN);
      set_req(32'h20);
      check("R2 masked irq", 32'(irq), 0);
      wr(2'd1, 32'h20);
      check("R2 unmasked irq", 32'(irq), 1);
      wr(2'd0, 32'h0);
      check("R3 enable off", 32'(irq), 0);
      wr(2'd0, EN);
      check("R3 enable on", 32'(irq), 1);
      set_req(32'h0);
      wr(2'd1, 32'h0);
   endtask

   task automatic t_prio_holdoff();
      logic [31:0] d;
      wr(2'd1, 32'hFFFF_FFFF);
      set_req(32'h228);
      ack(d);
      check("R4 R7 vector 9", d, 32'(9) << 11);
      rd(2'd2, d);
      check("R7 insvc set", d, 32'h200);
      check("R8 lower held off", 32'(irq), 0);
      set_req(32'h1228);
      check("R8 higher passes", 32'(irq), 1);
      set_req(32'h228);
      wr(2'd2, 32'h200);
      rd(2'd2, d);
      check("R9 eoi clears", d, 0);
      check("R9 irq after eoi", 32'(irq), 1);
      rd(2'd3, d);
      check("R7 unarmed read", d, 32'(9) << 11);
      rd(2'd2, d);
      check("R7 unarmed no mark", d, 0);
      set_req(32'h0);
   endtask

   task automatic t_error();
      logic [31:0] d;
      set_req(32'h1);
      check("R10 source 0 silent", 32'(irq), 0);
      ack(d);
      check("R10 error vector", d, 0);
      rd(2'd2, d);
      check("R10 nothing marked", d, 0);
      set_req(32'h0);
   endtask

   task automatic t_serial();
      logic [31:0] d;
      set_req(32'h0900_0000);
      ack(d);
      check("R5 tie to higher", d, 32'(27) << 11);
      wr(2'd2, 32'h0800_0000);
      wr(2'd0, EN | 32'h3);
      ack(d);
      check("R5 slot swap", d, 32'(24) << 11);
      rd(2'd2, d);
      check("R5 insvc 24", d, 32'h0100_0000);
      wr(2'd2, 32'h0100_0000);
      set_req(32'h0);
   endtask

   task automatic t_override();
      logic [31:0] d;
      wr(2'd0, EN | (32'd3 << 8));
      set_req(32'h0010_0008);
      ack(d);
      check("R6 override wins", d, 32'(3) << 11);
      set_req(32'h8010_0008);
      check("R6 R8 top holds all", 32'(irq), 0);
      wr(2'd2, 32'h8);
      check("R9 release", 32'(irq), 1);
      set_req(32'h0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(2'd0, EN | (32'd5 << 13));
      check("R11 level out", 32'(lvl), 5);
      set_req(32'h80);
      check("R11 level high", 32'(irq), 1);
      set_req(32'h0);
      check("R11 level drop", 32'(irq), 0);
      rd(2'd0, d);
      check("R11 cfg readback", d, EN | (32'd5 << 13));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_addr = '0; bus_wdata = '0; req = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask_enable();
      t_prio_holdoff();
      t_error();
      t_serial();
      t_override();
      t_level();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule